// File: doc/BRIEF.md
# Auto-Repeat Serial Transfer Interval Controller

This block is a synchronous serial master that runs at the CPU clock and moves a run of bytes through an internally generated serial clock. Software fills a small byte buffer, sets a byte count and pulses start. The block then sends each byte out most-significant bit first while capturing a byte from the serial input, and overwrites each buffer slot with the byte it received.

Between two bytes the serial clock rests high for a gap. The gap has a floor of two and a half serial-clock periods. It is also at least a number of CPU cycles that depends on the instruction class the CPU is running. It can optionally be raised by a programmed interval. The instruction class is sampled once, at the end of each byte, and sets the gap that follows that byte. A done flag rises right after the final byte, with no gap after it.

The serial clock period is `DIV` CPU cycles, where `DIV` is even and at least 2. Two and a half serial periods is therefore ceil(5·DIV/2) CPU cycles.

Top module: `sio_autoxfer`

## Requirements
- R1: After reset the serial clock output and the data output are 1, and busy and done are 0.
- R2: While the internal-clock select input is 0, a start pulse is ignored: busy stays 0 and the serial clock stays high.
- R3: Each byte leaves on the data output most-significant bit first. Each bit lasts DIV cycles and changes only when the serial clock falls. The serial clock is low for the first DIV/2 cycles of each bit period and high for the rest.
- R4: The serial input is sampled on each rising serial-clock edge, first bit as most-significant. The received byte replaces the buffer entry that was sent.
- R5: A start pulse with length input L (0..DEPTH-1) transfers L+1 bytes from buffer addresses 0 up to L in order.
- R6: The gap is counted in CPU cycles from the end of a byte's last bit period to the next falling clock edge. When the interval enable is 0, the gap is max(ceil(5·DIV/2), C), where C depends on the condition code.
- R7: The condition code sets C as follows: 2'b00 (other) gives C=7, 2'b01 (multiply) gives 13, 2'b10 (divide) gives 20 and 2'b11 (external access with one wait) gives 9.
- R8: When the interval enable is 1, the gap is the larger of the R6 value and (interval count + 1)·DIV cycles, where the interval count is a 5-bit input. When the enable is 0, the interval count has no effect.
- R9: The condition code is sampled in the cycle that ends a byte. A change during the gap that follows does not alter that gap.
- R10: During a gap the serial clock stays high and the data output holds the last bit sent.
- R11: Done rises in the cycle right after the final bit period ends, with no trailing gap. Busy falls at the same time. Done clears on the next accepted start.
- R12: Host writes to the buffer while busy is 1 are ignored. Host reads are always live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_clk_sel | input | 1 | 1 selects the internal serial clock and enables transfers |
| ivl_en | input | 1 | Enables the programmed interval |
| ivl_cnt | input | 5 | Programmed interval, in serial periods minus one |
| cpu_cond | input | 2 | Instruction-class code (see R7) |
| start | input | 1 | Start pulse |
| len_m1 | input | AW | Byte count minus one |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | AW | Host buffer address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Buffer contents at host_addr |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sequence finished |

## Verification
A wrong phase or bit counter shows up at once as a wrong spacing between serial-clock falls or as a wrong bit on the data output within the same byte. A wrong gap counter or gap choice shows up only as a stretched or shortened fall-to-fall interval across a byte boundary, so every gap is timed to the exact cycle. A wrong address or a wrong end-of-run compare changes which bytes leave, which slots get written back, or the cycle in which done rises. That is why the bench checks the buffer contents and the done cycle after every run.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } xfer_st_e;

    localparam logic [1:0] COND_OTHER = 2'd0;
    localparam logic [1:0] COND_MUL   = 2'd1;
    localparam logic [1:0] COND_DIV   = 2'd2;
    localparam logic [1:0] COND_XWAIT = 2'd3;

    localparam int CYC_OTHER = 7;
    localparam int CYC_MUL   = 13;
    localparam int CYC_DIV   = 20;
    localparam int CYC_XWAIT = 9;
endpackage

// File: rtl/sio_gap_calc.sv
module sio_gap_calc
    import sio_pkg::*;
#(
    parameter int DIV = 4,
    parameter int GW  = 8
) (
    input  logic [1:0]    cond,
    input  logic          prog_en,
    input  logic [4:0]    prog_val,
    output logic [GW-1:0] gap_len
);
    // two and a half serial periods, rounded up to whole CPU cycles
    localparam int FLOOR = (5 * DIV + 1) / 2;

    int cpu_cyc;
    int base_cyc;
    int prog_cyc;
    int tot_cyc;

    always_comb begin
        case (cond)
            COND_MUL:   cpu_cyc = CYC_MUL;
            COND_DIV:   cpu_cyc = CYC_DIV;
            COND_XWAIT: cpu_cyc = CYC_XWAIT;
            default:    cpu_cyc = CYC_OTHER;
        endcase
        base_cyc = (FLOOR > cpu_cyc) ? FLOOR : cpu_cyc;
        prog_cyc = (int'(prog_val) + 1) * DIV;
        tot_cyc  = (prog_en && (prog_cyc > base_cyc)) ? prog_cyc : base_cyc;
        gap_len  = GW'(tot_cyc);
    end
endmodule

// File: rtl/sio_xbuf.sv
module sio_xbuf #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem_q[eng_waddr] <= eng_wdata;
        end else if (host_we) begin
            mem_q[host_addr] <= host_wdata;
        end
    end

    assign eng_rdata  = mem_q[eng_raddr];
    assign host_rdata = mem_q[host_addr];
endmodule

// File: rtl/sio_autoxfer.sv
module sio_autoxfer
    import sio_pkg::*;
#(
    parameter int DIV   = 4,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_clk_sel,
    input  logic          ivl_en,
    input  logic [4:0]    ivl_cnt,
    input  logic [1:0]    cpu_cond,
    input  logic          start,
    input  logic [AW-1:0] len_m1,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          sck,
    output logic          sdo,
    input  logic          sdi,
    output logic          busy,
    output logic          done
);
    localparam int HALF    = DIV / 2;
    localparam int PW      = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int GAP_MAX = (32 * DIV > 20) ? 32 * DIV : 20;
    localparam int GW      = $clog2(GAP_MAX + 1);

    typedef struct packed {
        xfer_st_e      st;
        logic [PW-1:0] ph;
        logic [2:0]    bitc;
        logic [AW-1:0] addr;
        logic [AW-1:0] last;
        logic [GW-1:0] gcnt;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          sck;
        logic          sdo;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;

    logic          eng_we;
    logic [AW-1:0] eng_raddr;
    logic [7:0]    eng_rdata;
    logic [GW-1:0] gap_len;
    logic          host_we_ok;

    sio_gap_calc #(.DIV(DIV), .GW(GW)) u_gap (
        .cond     (cpu_cond),
        .prog_en  (ivl_en),
        .prog_val (ivl_cnt),
        .gap_len  (gap_len)
    );

    assign host_we_ok = host_we && (r_q.st == ST_IDLE);
    assign eng_raddr  = (r_q.st == ST_IDLE) ? '0 : r_q.addr;

    sio_xbuf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk        (clk),
        .eng_we     (eng_we),
        .eng_waddr  (r_q.addr),
        .eng_wdata  (r_q.rx),
        .eng_raddr  (eng_raddr),
        .eng_rdata  (eng_rdata),
        .host_we    (host_we_ok),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    always_comb begin
        r_d    = r_q;
        eng_we = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start && int_clk_sel) begin
                    r_d.st   = ST_SHIFT;
                    r_d.ph   = '0;
                    r_d.bitc = '0;
                    r_d.addr = '0;
                    r_d.last = len_m1;
                    r_d.sh   = eng_rdata;
                    r_d.sdo  = eng_rdata[7];
                    r_d.sck  = 1'b0;
                    r_d.done = 1'b0;
                end
            end
            ST_SHIFT: begin
                r_d.ph = r_q.ph + PW'(1);
                if (r_q.ph == PW'(HALF - 1)) begin
                    r_d.sck = 1'b1;
                    r_d.rx  = {r_q.rx[6:0], sdi};
                end
                if (r_q.ph == PW'(DIV - 1)) begin
                    r_d.ph = '0;
                    if (r_q.bitc != 3'd7) begin
                        r_d.bitc = r_q.bitc + 3'd1;
                        r_d.sh   = {r_q.sh[6:0], 1'b0};
                        r_d.sdo  = r_q.sh[6];
                        r_d.sck  = 1'b0;
                    end else begin
                        eng_we   = 1'b1;
                        r_d.bitc = '0;
                        if (r_q.addr == r_q.last) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st   = ST_GAP;
                            r_d.gcnt = gap_len - GW'(1);
                            r_d.addr = r_q.addr + AW'(1);
                        end
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gcnt == '0) begin
                    r_d.st  = ST_SHIFT;
                    r_d.ph  = '0;
                    r_d.sh  = eng_rdata;
                    r_d.sdo = eng_rdata[7];
                    r_d.sck = 1'b0;
                end else begin
                    r_d.gcnt = r_q.gcnt - GW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sck  <= 1'b1;
            r_q.sdo  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck  = r_q.sck;
    assign sdo  = r_q.sdo;
    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;

    // R10
    sck_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_SHIFT) |-> sck);

    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sck) |-> $stable(sdo));

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !int_clk_sel) |=> !busy);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.addr <= r_q.last));

    // R8
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GAP) |-> (r_q.gcnt < GW'(GAP_MAX)));
endmodule

// File: tb/sio_autoxfer_test.sv
module sio_autoxfer_test;
    localparam int N = 4;
    localparam int FLOOR = (5 * N + 1) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_clk_sel = 1'b1;
    logic ivl_en = 1'b0;
    logic [4:0] ivl_cnt = '0;
    logic [1:0] cpu_cond = 2'd0;
    logic start = 1'b0;
    logic [4:0] len_m1 = '0;
    logic host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic sck, sdo, busy, done;
    logic sdi = 1'b0;

    always #10 clk = ~clk;

    sio_autoxfer #(.DIV(N), .DEPTH(32)) uut (
        .clk(clk), .rst_n(rst_n), .int_clk_sel(int_clk_sel),
        .ivl_en(ivl_en), .ivl_cnt(ivl_cnt), .cpu_cond(cpu_cond),
        .start(start), .len_m1(len_m1), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sck(sck), .sdo(sdo), .sdi(sdi),
        .busy(busy), .done(done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int falls [0:255];
    logic sdo_at [0:255];
    int nfall = 0, nrise = 0, sdo_bad = 0, done_cyc = -1;
    logic prev_sck = 1'b1, prev_sdo = 1'b1, prev_done = 1'b0;
    logic [7:0] slv [0:31];
    logic [7:0] txb [0:31];
    int gexp [0:31];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_sck && !sck) begin
            if (nfall < 256) begin
                falls[nfall]  = cyc;
                sdo_at[nfall] = sdo;
                sdi = slv[(nfall / 8) % 32][7 - (nfall % 8)];
            end
            nfall = nfall + 1;
        end else if (sdo != prev_sdo) begin
            sdo_bad = sdo_bad + 1;
        end
        if (!prev_sck && sck) nrise = nrise + 1;
        if (!prev_done && done) done_cyc = cyc;
        prev_sck = sck; prev_sdo = sdo; prev_done = done;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 5'(a);
        #1 d = host_rdata;
    endtask

    task automatic start_xfer(input int nbytes);
        @(negedge clk);
        nfall = 0; nrise = 0; sdo_bad = 0; done_cyc = -1;
        start = 1'b1; len_m1 = 5'(nbytes - 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_bytes(input int nbytes, input int seed);
        for (int i = 0; i < nbytes; i++) begin
            txb[i] = 8'((seed + i * 37) ^ 8'h5A);
            slv[i] = 8'(~txb[i] + 8'(i));
            host_write(i, txb[i]);
        end
    endtask

    // checks bit order, timing, writeback and done cycle of the last run
    task automatic verify_run(input int nbytes, input string tag);
        int bad_int = 0, bad_tx = 0, bad_rx = 0, tot = 0;
        logic [7:0] rd;
        check({tag, " R5 fall count"}, nfall, 8 * nbytes);
        check({tag, " R3 rise count"}, nrise, 8 * nbytes);
        for (int j = 1; j < 8 * nbytes && j < 256; j++) begin
            int e;
            e = (j % 8 == 0) ? N + gexp[j / 8] : N;
            if (falls[j] - falls[j - 1] != e) bad_int++;
        end
        check({tag, " R6 R3 fall spacing mismatches"}, bad_int, 0);
        for (int j = 0; j < 8 * nbytes && j < 256; j++)
            if (sdo_at[j] != txb[j / 8][7 - (j % 8)]) bad_tx++;
        check({tag, " R3 sdo bit mismatches"}, bad_tx, 0);
        check({tag, " R10 sdo changed off fall"}, sdo_bad, 0);
        for (int i = 0; i < nbytes; i++) begin
            host_read(i, rd);
            if (rd != slv[i]) bad_rx++;
        end
        check({tag, " R4 writeback mismatches"}, bad_rx, 0);
        tot = falls[0] + 8 * N * nbytes;
        for (int k = 1; k < nbytes; k++) tot += gexp[k];
        check({tag, " R11 done cycle"}, done_cyc, tot);
        check({tag, " R11 busy low"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        check("R1 sck", int'(sck), 1);
        check("R1 sdo", int'(sdo), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_no_clock();
        int_clk_sel = 1'b0;
        start_xfer(2);
        repeat (20) @(negedge clk);
        check("R2 busy", int'(busy), 0);
        check("R2 falls", nfall, 0);
        int_clk_sel = 1'b1;
    endtask

    task automatic t_run(input int nbytes, input logic [1:0] c, input logic en,
                         input logic [4:0] v, input int g, input string tag);
        load_bytes(nbytes, nbytes * 11 + int'(c));
        cpu_cond = c; ivl_en = en; ivl_cnt = v;
        for (int k = 0; k < 32; k++) gexp[k] = g;
        start_xfer(nbytes);
        check({tag, " R11 done cleared"}, int'(done), 0);
        check({tag, " R5 busy"}, int'(busy), 1);
        wait_done();
        verify_run(nbytes, tag);
    endtask

    // R9: condition code changed inside the first gap
    task automatic t_sample_point();
        load_bytes(3, 99);
        cpu_cond = 2'd1; ivl_en = 1'b0;
        gexp[1] = 13; gexp[2] = FLOOR;
        start_xfer(3);
        while (nfall < 1) @(negedge clk);
        while (cyc < falls[0] + 8 * N + 2) @(negedge clk);
        cpu_cond = 2'd0;
        wait_done();
        verify_run(3, "R9");
    endtask

    // R12: host write while busy
    task automatic t_busy_write();
        load_bytes(3, 5);
        cpu_cond = 2'd0; ivl_en = 1'b0;
        for (int k = 0; k < 32; k++) gexp[k] = FLOOR;
        start_xfer(3);
        host_write(2, ~txb[2]);
        host_write(1, 8'h00);
        wait_done();
        verify_run(3, "R12");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) slv[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_clock();
        t_run(1, 2'd0, 1'b0, 5'd0, FLOOR, "single");
        t_run(3, 2'd0, 1'b0, 5'd31, FLOOR, "R6 R8 other");
        t_run(3, 2'd1, 1'b0, 5'd0, 13, "R7 mul");
        t_run(3, 2'd2, 1'b0, 5'd0, 20, "R7 div");
        t_run(2, 2'd3, 1'b0, 5'd0, FLOOR, "R7 xwait");
        t_run(3, 2'd0, 1'b1, 5'd3, 16, "R8 prog");
        t_run(2, 2'd2, 1'b1, 5'd3, 20, "R8 cpu wins");
        t_run(2, 2'd0, 1'b1, 5'd0, FLOOR, "R8 floor wins");
        t_run(32, 2'd1, 1'b1, 5'd1, 13, "R5 full");
        t_sample_point();
        t_busy_write();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule